// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit logical address into a final page descriptor. It walks a table tree held in memory with three levels: a root table, then a pointer table, then a page table. The walk starts from the supervisor root pointer or the user root pointer, depending on the privilege of the access. Page sizes of 4 KiB and 8 KiB are chosen per walk. A page entry may be indirect. In that case the walker makes one more read to fetch the real descriptor.

As it goes, the walker keeps the in-memory used and modified flags up to date. It writes a descriptor back only when one of those flags actually changes. Write protection from the upper two levels is ORed into the descriptor it returns. Memory is reached through a single 32-bit port with separate read and write strobes. There is at most one request in flight, and it is held until acknowledged. A caller pulses `start` and waits for the one-cycle `done` pulse, when `result` carries the descriptor.

Descriptor bits: bit 0 marks a resident page, bit 1 marks a valid root or pointer entry, bit 2 is write protect, bit 3 is used and bit 4 is modified. Page type bits [1:0] equal to 2 mark an indirect page entry.

Top module: `pt_walker`

## Requirements
- R1: The first read is at the selected root pointer (supervisor pointer when `supervisor`=1, else user pointer) with bits 8:0 cleared, ORed with logical bits 31:25 shifted left by 2.
- R2: The second read is at the root descriptor with bits 8:0 cleared, ORed with logical bits 24:18 shifted left by 2.
- R3: The page read is at the pointer descriptor with bits 7:0 cleared ORed with logical bits 17:12 shifted left by 2 when `page_8k`=0, or with bits 6:0 cleared ORed with logical bits 17:13 shifted left by 2 when `page_8k`=1.
- R4: A root or pointer descriptor with bit 1 clear ends the walk with `result` = 0 and makes no further memory access.
- R5: A valid root or pointer descriptor with bit 3 clear is written back to the address it was read from, with bit 3 set, before the next level is read.
- R6: A page entry with bits [1:0] = 2 causes exactly one further read, at that entry with bits 1:0 cleared. The entry read there is used as the page descriptor whatever its type.
- R7: A page descriptor with bit 0 clear is returned unchanged, with no writeback.
- R8: Bit 2 of the returned resident descriptor is the OR of bit 2 of the root, pointer and page descriptors.
- R9: On a write access with no accumulated write protect, bits 3 and 4 are both set in the result. The descriptor is written back only if at least one of them was clear.
- R10: On a read, or on a write-protected write, only bit 3 is set. A writeback happens only if bit 3 was clear.
- R11: Read and write strobes are never both high. A request keeps its address and strobe until `mem_ack`. `done` is high for exactly one cycle per walk.
- R12: After reset no strobe is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| logical_addr | input | 32 | Address to translate |
| supervisor | input | 1 | Privilege of the access; selects the root pointer |
| is_write | input | 1 | Access is a write |
| page_8k | input | 1 | 1 selects 8 KiB pages, 0 selects 4 KiB |
| super_root | input | 32 | Supervisor root pointer |
| user_root | input | 32 | User root pointer |
| mem_rd | output | 1 | Read request strobe |
| mem_wr | output | 1 | Write request strobe |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle walk-complete pulse |
| result | output | 32 | Final descriptor (0 for an invalid upper level) |

## Verification
Directed walks each isolate one path: an invalid root entry, an invalid pointer entry, an indirect page, a non-resident page, a write with both flags already set, a write behind a protected pointer, a plain read that sets only the used flag, an 8 KiB page, and a user-mode walk. The user-mode walk, with the supervisor table left empty, shows that the wrong root pointer would give an invalid result. Random walks use garbage in the low root-pointer bits, random flag bits at every level and all four page types, with random memory latency. The full access sequence (addresses and read/write kind) is compared with a bench model, which separates address-formation errors from flag-update errors. The whole memory is compared afterwards, which catches spurious or missing writebacks.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int AW = 32;
    localparam int DW = 32;

    localparam int ROOT_IDX_LSB = 25;
    localparam int PTR_IDX_LSB  = 18;
    localparam int PG_IDX_MSB   = 17;
    localparam int PG4_IDX_LSB  = 12;
    localparam int PG8_IDX_LSB  = 13;
    localparam int TBL_ALIGN    = 9;
    localparam int PG4_ALIGN    = PG_IDX_MSB - PG4_IDX_LSB + 3;
    localparam int PG8_ALIGN    = PG_IDX_MSB - PG8_IDX_LSB + 3;

    localparam int D_RES  = 0;
    localparam int D_VLD  = 1;
    localparam int D_WP   = 2;
    localparam int D_USED = 3;
    localparam int D_MOD  = 4;
    localparam logic [1:0] TYPE_INDIR = 2'b10;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROOT, ST_PTR, ST_PAGE, ST_INDIR, ST_WB, ST_DONE
    } walk_st_e;

    typedef struct packed {
        desc_t desc;
        logic  resident;
        logic  wb;
    } pg_upd_t;

    function automatic addr_t clr_low(addr_t a, int n);
        return a & ~((addr_t'(1) << n) - addr_t'(1));
    endfunction

    function automatic addr_t root_addr(addr_t rp, addr_t va);
        return clr_low(rp, TBL_ALIGN) | addr_t'({va[AW-1:ROOT_IDX_LSB], 2'b00});
    endfunction

    function automatic addr_t ptr_addr(desc_t d, addr_t va);
        return clr_low(addr_t'(d), TBL_ALIGN) | addr_t'({va[ROOT_IDX_LSB-1:PTR_IDX_LSB], 2'b00});
    endfunction

    function automatic addr_t page_addr(desc_t d, addr_t va, logic big);
        if (big)
            return clr_low(addr_t'(d), PG8_ALIGN) | addr_t'({va[PG_IDX_MSB:PG8_IDX_LSB], 2'b00});
        return clr_low(addr_t'(d), PG4_ALIGN) | addr_t'({va[PG_IDX_MSB:PG4_IDX_LSB], 2'b00});
    endfunction
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
    import pgw_pkg::*;
(
    input  addr_t va,
    input  addr_t root_ptr,
    input  desc_t rdata,
    input  logic  big_page,
    output addr_t root_a,
    output addr_t ptr_a,
    output addr_t page_a,
    output addr_t indir_a
);
    always_comb begin
        root_a  = root_addr(root_ptr, va);
        ptr_a   = ptr_addr(rdata, va);
        page_a  = page_addr(rdata, va, big_page);
        indir_a = clr_low(addr_t'(rdata), 2);
    end
endmodule

// File: rtl/pgw_page_upd.sv
module pgw_page_upd
    import pgw_pkg::*;
(
    input  desc_t   raw,
    input  logic    wp_acc,
    input  logic    wr,
    output pg_upd_t upd
);
    desc_t merged;
    desc_t flagged;

    always_comb begin
        merged = raw;
        merged[D_WP] = raw[D_WP] | wp_acc;
        flagged = merged;
        flagged[D_USED] = 1'b1;
        if (wr && !merged[D_WP])
            flagged[D_MOD] = 1'b1;
        upd.resident = raw[D_RES];
        upd.desc     = raw[D_RES] ? flagged : raw;
        upd.wb       = raw[D_RES] &&
                       ({flagged[D_MOD], flagged[D_USED]} != {raw[D_MOD], raw[D_USED]});
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] logical_addr,
    input  logic        supervisor,
    input  logic        is_write,
    input  logic        page_8k,
    input  logic [31:0] super_root,
    input  logic [31:0] user_root,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [31:0] result
);
    walk_st_e st, ret_st;
    addr_t    va_q, req_addr, nxt_addr;
    desc_t    wdata_q, result_q;
    logic     wr_q, big_q, wp_q;

    addr_t    va_sel, root_a, ptr_a, page_a, indir_a;
    pg_upd_t  upd;
    logic     page_final;

    assign va_sel = (st == ST_IDLE) ? logical_addr : va_q;

    pgw_addr_gen u_addr (
        .va       (va_sel),
        .root_ptr (supervisor ? super_root : user_root),
        .rdata    (mem_rdata),
        .big_page (big_q),
        .root_a   (root_a),
        .ptr_a    (ptr_a),
        .page_a   (page_a),
        .indir_a  (indir_a)
    );

    pgw_page_upd u_upd (
        .raw    (mem_rdata),
        .wp_acc (wp_q),
        .wr     (wr_q),
        .upd    (upd)
    );

    assign page_final = (st == ST_INDIR) ||
                        (st == ST_PAGE && mem_rdata[1:0] != TYPE_INDIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ret_st   <= ST_IDLE;
            va_q     <= '0;
            req_addr <= '0;
            nxt_addr <= '0;
            wdata_q  <= '0;
            result_q <= '0;
            wr_q     <= 1'b0;
            big_q    <= 1'b0;
            wp_q     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    va_q     <= logical_addr;
                    wr_q     <= is_write;
                    big_q    <= page_8k;
                    wp_q     <= 1'b0;
                    req_addr <= root_a;
                    st       <= ST_ROOT;
                end
                ST_ROOT, ST_PTR: if (mem_ack) begin
                    if (!mem_rdata[D_VLD]) begin
                        result_q <= '0;
                        st       <= ST_DONE;
                    end else begin
                        wp_q <= wp_q | mem_rdata[D_WP];
                        if (!mem_rdata[D_USED]) begin
                            wdata_q         <= mem_rdata;
                            wdata_q[D_USED] <= 1'b1;
                            nxt_addr        <= (st == ST_ROOT) ? ptr_a : page_a;
                            ret_st          <= (st == ST_ROOT) ? ST_PTR : ST_PAGE;
                            st              <= ST_WB;
                        end else begin
                            req_addr <= (st == ST_ROOT) ? ptr_a : page_a;
                            st       <= (st == ST_ROOT) ? ST_PTR : ST_PAGE;
                        end
                    end
                end
                ST_PAGE, ST_INDIR: if (mem_ack) begin
                    if (!page_final) begin
                        req_addr <= indir_a;
                        st       <= ST_INDIR;
                    end else begin
                        result_q <= upd.desc;
                        if (upd.wb) begin
                            wdata_q <= upd.desc;
                            ret_st  <= ST_DONE;
                            st      <= ST_WB;
                        end else begin
                            st <= ST_DONE;
                        end
                    end
                end
                ST_WB: if (mem_ack) begin
                    req_addr <= nxt_addr;
                    st       <= ret_st;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd    = (st == ST_ROOT) || (st == ST_PTR) || (st == ST_PAGE) || (st == ST_INDIR);
    assign mem_wr    = (st == ST_WB);
    assign mem_addr  = req_addr;
    assign mem_wdata = wdata_q;
    assign done      = (st == ST_DONE);
    assign result    = result_q;

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) && !mem_ack |=> $stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_wb_used_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_wdata[D_USED]);
    p_invalid_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ROOT || st == ST_PTR) && mem_ack && !mem_rdata[D_VLD] |=> done && result == '0);
    p_indir_once_r6: assert property (@(posedge clk) disable iff (rst)
        st == ST_INDIR && mem_ack |=> !mem_rd);
    p_nonres_r7: assert property (@(posedge clk) disable iff (rst)
        page_final && mem_ack && !mem_rdata[D_RES] |=> done && result == $past(mem_rdata));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] logical_addr = '0;
    logic        supervisor = 1'b0;
    logic        is_write = 1'b0;
    logic        page_8k = 1'b0;
    logic [31:0] sroot = '0;
    logic [31:0] uroot = '0;
    logic        mem_rd, mem_wr, mem_ack, done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, result;

    logic [31:0] mem [0:1023];
    logic [31:0] mm  [0:1023];
    logic [31:0] got_a [0:7];
    logic        got_w [0:7];
    logic [31:0] exp_a [0:7];
    logic        exp_w [0:7];
    int          got_n, exp_n;
    logic [31:0] exp_res;
    int          wait_c;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst(rst), .start(start), .logical_addr(logical_addr),
        .supervisor(supervisor), .is_write(is_write), .page_8k(page_8k),
        .super_root(sroot), .user_root(uroot),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .result(result)
    );

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wait_c    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_rd || mem_wr) begin
            if (wait_c != 0) wait_c <= wait_c - 1;
            else begin
                mem_ack <= 1'b1;
                if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
                else mem[mem_addr[11:2]] = mem_wdata;
                if (got_n < 8) begin
                    got_a[got_n] = mem_addr;
                    got_w[got_n] = mem_wr;
                end
                got_n = got_n + 1;
                wait_c <= $urandom_range(0, 2);
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        mem[a[11:2]] = d;
        mm[a[11:2]]  = d;
    endtask

    task automatic rec(input logic [31:0] a, input logic w);
        if (exp_n < 8) begin
            exp_a[exp_n] = a;
            exp_w[exp_n] = w;
        end
        exp_n++;
    endtask

    task automatic ref_walk(input logic [31:0] va, input logic sup, input logic wr, input logic big);
        logic [31:0] a, d, n;
        logic wp;
        exp_n = 0;
        a = ((sup ? sroot : uroot) & ~32'h1FF) | {23'd0, va[31:25], 2'b00};
        d = mm[a[11:2]]; rec(a, 1'b0);
        if (!d[1]) begin exp_res = '0; return; end
        wp = d[2];
        if (!d[3]) begin mm[a[11:2]] = d | 32'h8; rec(a, 1'b1); end
        a = (d & ~32'h1FF) | {23'd0, va[24:18], 2'b00};
        d = mm[a[11:2]]; rec(a, 1'b0);
        if (!d[1]) begin exp_res = '0; return; end
        wp = wp | d[2];
        if (!d[3]) begin mm[a[11:2]] = d | 32'h8; rec(a, 1'b1); end
        a = big ? ((d & ~32'h7F) | {25'd0, va[17:13], 2'b00})
                : ((d & ~32'hFF) | {24'd0, va[17:12], 2'b00});
        d = mm[a[11:2]]; rec(a, 1'b0);
        if (d[1:0] == 2'b10) begin
            a = d & ~32'h3;
            d = mm[a[11:2]]; rec(a, 1'b0);
        end
        if (!d[0]) begin exp_res = d; return; end
        if (wp) d[2] = 1'b1;
        n = (wr && !d[2]) ? (d | 32'h18) : (d | 32'h8);
        if (n[4:3] != d[4:3]) begin mm[a[11:2]] = n; rec(a, 1'b1); end
        exp_res = n;
    endtask

    task automatic build(input logic [31:0] va, input logic sup, input logic big,
                         input logic [31:0] rlo, input logic [31:0] plo,
                         input logic [31:0] pgd, input logic [31:0] tgt);
        logic [31:0] ra, pa;
        for (int i = 0; i < 1024; i++) begin mem[i] = '0; mm[i] = '0; end
        sroot = 32'h000 | ($urandom & 32'h1FF);
        uroot = 32'h200 | ($urandom & 32'h1FF);
        ra = ((sup ? sroot : uroot) & ~32'h1FF) | {23'd0, va[31:25], 2'b00};
        put(ra, 32'h400 | (rlo & 32'h1FF));
        put(32'h400 | {23'd0, va[24:18], 2'b00}, 32'h800 | (plo & (big ? 32'h7F : 32'hFF)));
        pa = big ? (32'h800 | {25'd0, va[17:13], 2'b00}) : (32'h800 | {24'd0, va[17:12], 2'b00});
        put(pa, pgd);
        if (pgd[1:0] == 2'b10) put(pgd & ~32'h3, tgt);
    endtask

    task automatic run(input logic [31:0] va, input logic sup, input logic wr,
                       input logic big, input string tag);
        int cyc;
        logic same;
        ref_walk(va, sup, wr, big);
        @(negedge clk);
        logical_addr = va; supervisor = sup; is_write = wr; page_8k = big;
        got_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 300) begin @(negedge clk); cyc++; end
        chk(done, tag, "walk completes", 32'(cyc), 32'd0);
        chk(result == exp_res, tag, "result", result, exp_res);
        same = (got_n == exp_n);
        for (int i = 0; i < 8; i++)
            if (i < exp_n && (got_a[i] != exp_a[i] || got_w[i] != exp_w[i])) same = 1'b0;
        chk(same, tag, "access sequence length/order", 32'(got_n), 32'(exp_n));
        @(negedge clk);
        chk(!done, "R11", "done single cycle", 32'(done), 32'd0);
        same = 1'b1;
        for (int i = 0; i < 1024; i++) if (mem[i] != mm[i]) same = 1'b0;
        chk(same, tag, "memory image", 32'(same), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        got_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: idle after reset
        chk(!mem_rd && !mem_wr && !done, "R12", "idle outputs", {29'd0, mem_rd, mem_wr, done}, 32'd0);

        // R5 R10: read with used clear everywhere, 4 KiB
        build(32'h1234_5678, 1'b1, 1'b0, 32'h002, 32'h002, 32'hABCD_E001, 32'h0);
        run(32'h1234_5678, 1'b1, 1'b0, 1'b0, "R5 R10");
        // R4: invalid root
        build(32'h8000_1000, 1'b1, 1'b0, 32'h000, 32'h00A, 32'h0000_5009, 32'h0);
        run(32'h8000_1000, 1'b1, 1'b0, 1'b0, "R4");
        // R4: invalid pointer
        build(32'h0404_0000, 1'b1, 1'b0, 32'h00A, 32'h008, 32'h0000_5009, 32'h0);
        run(32'h0404_0000, 1'b1, 1'b1, 1'b0, "R4");
        // R6: indirect page entry
        build(32'h7777_7777, 1'b1, 1'b0, 32'h00A, 32'h00A, 32'h0000_0D42, 32'h1234_5011);
        run(32'h7777_7777, 1'b1, 1'b1, 1'b0, "R6");
        // R7: non-resident page
        build(32'h0ABC_D000, 1'b1, 1'b0, 32'h00A, 32'h00A, 32'hFEED_F0F4, 32'h0);
        run(32'h0ABC_D000, 1'b1, 1'b1, 1'b0, "R7");
        // R9: write, U and M already set: no writeback
        build(32'h3333_3000, 1'b1, 1'b0, 32'h00A, 32'h00A, 32'h5555_5019, 32'h0);
        run(32'h3333_3000, 1'b1, 1'b1, 1'b0, "R9");
        // R9: write, only U set: M added
        build(32'h3333_3000, 1'b1, 1'b0, 32'h00A, 32'h00A, 32'h5555_5009, 32'h0);
        run(32'h3333_3000, 1'b1, 1'b1, 1'b0, "R9");
        // R8 R10: write behind protected pointer: only U set
        build(32'h2468_ACE0, 1'b1, 1'b0, 32'h00A, 32'h00E, 32'h9999_9001, 32'h0);
        run(32'h2468_ACE0, 1'b1, 1'b1, 1'b0, "R8 R10");
        // R3: 8 KiB page
        build(32'h5A5A_F000, 1'b1, 1'b1, 32'h00A, 32'h00A, 32'h4444_4001, 32'h0);
        run(32'h5A5A_F000, 1'b1, 1'b0, 1'b1, "R3");
        // R1: user root selected
        build(32'hC0DE_1000, 1'b0, 1'b0, 32'h00A, 32'h00A, 32'h1111_1001, 32'h0);
        run(32'hC0DE_1000, 1'b0, 1'b1, 1'b0, "R1");

        for (int k = 0; k < 40; k++) begin
            logic [31:0] va, rlo, plo, pgd, tgt;
            logic sup, wr, big;
            va  = $urandom; sup = 1'($urandom); wr = 1'($urandom); big = 1'($urandom);
            rlo = $urandom & 32'h1FF; if ($urandom_range(0, 7) != 0) rlo = rlo | 32'h2;
            plo = $urandom & 32'h1FF; if ($urandom_range(0, 7) != 0) plo = plo | 32'h2;
            pgd = ($urandom & ~32'h3) | 32'($urandom_range(0, 3));
            if (pgd[1:0] == 2'b10) pgd = 32'h0000_0C00 | (32'($urandom_range(0, 255)) << 2) | 32'h2;
            tgt = $urandom;
            build(va, sup, big, rlo, plo, pgd, tgt);
            run(va, sup, wr, big, "R1 R2 R3 R8");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule